// File: doc/BRIEF.md
# Serial Flash Status Register and Write Guard

This block keeps the protection-related state of a serial flash status register and rules on every modifying command before the command engine starts it. It stores the status-register-write-disable bit and a three-bit block-protect code, builds the readable status byte from that state and from the engine's write-in-progress and write-enable-latch levels, and answers each program, write or erase request with an accept or reject verdict.

The protect code shields a region that grows down from the top of the array in whole sectors. An optional per-sector lock mask adds further shielded sectors. The status register itself is frozen while its write-disable bit is set and the write-protect pin is held low.

Both request channels are single-cycle strobes with no back-pressure. The block is always ready, and each request gets exactly one response pulse on the following cycle. The engine must act on the verdict itself: it clears its write-enable latch whether the request is accepted or refused, and it starts a cycle only on an accept.

Top module: `sr_guard`

## Requirements
- R1: `status_o` is {wd, 0, 0, bp[2], bp[1], bp[0], wel_i, wip_i}, from bit 7 down to bit 0. Bits 1 and 0 follow `wel_i` and `wip_i` in the same cycle.
- R2: After reset, `status_o[7:2]` is 0 and both response strobes are low.
- R3: A status write is accepted when `wel_i`=1, `wip_i`=0, and either wd=0 or `wp_n_i`=1. On acceptance, data bit 7 becomes wd and data bits 4:2 become bp. These values are visible from the cycle after the request. Data bits 6, 5, 1 and 0 have no effect.
- R4: A status write with `wel_i`=0 or `wip_i`=1 is refused, and the stored bits stay unchanged.
- R5: A status write made while wd=1 and `wp_n_i`=0 is refused, and the stored bits stay unchanged.
- R6: The number of protected top sectors is 0 for bp=0 and min(2^(bp-1), SECTORS) for any other bp. With 8 sectors, bp=1..7 protect 1, 2, 4, 8, 8, 8 and 8 sectors. Sector index = `op_addr_i[18:16]` with the default parameters.
- R7: The operation codes are 0 page program, 1 page write, 2 page erase, 3 subsector erase and 4 sector erase. A request with one of these codes is refused when its sector is protected by bp or has its bit set in `lock_mask_i`.
- R8: Operation code 5 is bulk erase. It is refused when bp is not 0 or when any lock bit is set.
- R9: Every operation is refused when `wel_i`=0 or `wip_i`=1. Codes 6 and 7 are always refused.
- R10: `op_resp_valid_o` and `swr_resp_valid_o` pulse high for exactly the one cycle after their request strobe, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_n_i | input | 1 | Write-protect pin level, low means protect asserted |
| wip_i | input | 1 | Write in progress, from the command engine |
| wel_i | input | 1 | Write-enable latch, from the command engine |
| swr_valid_i | input | 1 | Status write request strobe |
| swr_data_i | input | 8 | Status write data byte |
| op_valid_i | input | 1 | Modifying operation request strobe |
| op_kind_i | input | 3 | Operation code (see R7 to R9) |
| op_addr_i | input | 19 | Target byte address |
| lock_mask_i | input | 8 | Per-sector lock bits, one per sector |
| status_o | output | 8 | Readable status byte |
| swr_resp_valid_o | output | 1 | Status write response strobe |
| swr_resp_ok_o | output | 1 | Status write accepted |
| op_resp_valid_o | output | 1 | Operation response strobe |
| op_resp_ok_o | output | 1 | Operation accepted |

## Verification
The bench sweeps all eight protect codes against every operation code and every sector. An off-by-one in the top-region map would therefore wrongly accept or refuse requests in the boundary sector, and a map that failed to saturate at codes 5 to 7 would let requests into the lower sectors. Each lock bit is tried alone against every operation, which catches lock logic applied to the wrong sector, and bulk erase is tried against each cause that should block it. The hardware freeze is tried with the pin at both levels. A status write of all ones checks that the unused data bits are dropped and that the engine-owned bits are never latched from the data.

// File: rtl/sr_guard_pkg.sv
`timescale 1ns/1ps
package sr_guard_pkg;

  typedef enum logic [2:0] {
    K_PROG  = 3'd0,
    K_PWR   = 3'd1,
    K_PERA  = 3'd2,
    K_SUBER = 3'd3,
    K_SECER = 3'd4,
    K_BULK  = 3'd5
  } op_kind_e;

  // number of top sectors shielded by a protect code
  function automatic int unsigned guarded_count(input logic [2:0] code,
                                                input int unsigned sectors);
    int unsigned n;
    if (code == 3'd0) begin
      n = 0;
    end else begin
      n = 32'd1 << (code - 3'd1);
      if (n > sectors) n = sectors;
    end
    return n;
  endfunction

endpackage

// File: rtl/sr_guard_regs.sv
`timescale 1ns/1ps
module sr_guard_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       swr_valid_i,
  input  logic [7:0] swr_data_i,
  input  logic       wel_i,
  input  logic       wip_i,
  input  logic       wp_n_i,
  output logic       wd_o,
  output logic [2:0] bp_o,
  output logic       resp_valid_o,
  output logic       resp_ok_o
);
  logic frozen;
  logic accept;
  logic unused_bits;

  assign frozen      = wd_o & ~wp_n_i;
  assign accept      = swr_valid_i & wel_i & ~wip_i & ~frozen;
  assign unused_bits = ^{swr_data_i[6:5], swr_data_i[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_o         <= 1'b0;
      bp_o         <= 3'd0;
      resp_valid_o <= 1'b0;
      resp_ok_o    <= 1'b0;
    end else begin
      resp_valid_o <= swr_valid_i;
      resp_ok_o    <= accept;
      if (accept) begin
        wd_o <= swr_data_i[7];
        bp_o <= swr_data_i[4:2];
      end
    end
  end
endmodule

// File: rtl/sr_guard_map.sv
`timescale 1ns/1ps
module sr_guard_map #(
  parameter int SECTORS = 8
) (
  input  logic [2:0]         bp_i,
  output logic [SECTORS-1:0] prot_o
);
  import sr_guard_pkg::*;

  int unsigned span;
  always_comb span = guarded_count(bp_i, SECTORS);

  for (genvar s = 0; s < SECTORS; s++) begin : g_sec
    assign prot_o[s] = (32'(s) + span) >= 32'(SECTORS);
  end
endmodule

// File: rtl/sr_guard_judge.sv
`timescale 1ns/1ps
module sr_guard_judge #(
  parameter int SECTORS = 8,
  localparam int SEC_W = $clog2(SECTORS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid_i,
  input  logic [2:0]         op_kind_i,
  input  logic [SEC_W-1:0]   sector_i,
  input  logic [SECTORS-1:0] prot_i,
  input  logic [SECTORS-1:0] lock_i,
  input  logic               wel_i,
  input  logic               wip_i,
  output logic               resp_valid_o,
  output logic               resp_ok_o
);
  import sr_guard_pkg::*;

  logic sector_hit;
  logic any_guard;
  logic region_ok;
  logic verdict;

  assign sector_hit = prot_i[sector_i] | lock_i[sector_i];
  assign any_guard  = (|prot_i) | (|lock_i);

  always_comb begin
    unique case (op_kind_i)
      K_PROG, K_PWR, K_PERA, K_SUBER, K_SECER: region_ok = ~sector_hit;
      K_BULK:                                  region_ok = ~any_guard;
      default:                                 region_ok = 1'b0;
    endcase
  end

  assign verdict = wel_i & ~wip_i & region_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid_o <= 1'b0;
      resp_ok_o    <= 1'b0;
    end else begin
      resp_valid_o <= op_valid_i;
      resp_ok_o    <= op_valid_i & verdict;
    end
  end
endmodule

// File: rtl/sr_guard.sv
`timescale 1ns/1ps
module sr_guard #(
  parameter int SECTORS = 8,
  parameter int SECTOR_AW = 16,
  localparam int SEC_W = $clog2(SECTORS),
  localparam int ADDR_W = SEC_W + SECTOR_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wp_n_i,
  input  logic               wip_i,
  input  logic               wel_i,
  input  logic               swr_valid_i,
  input  logic [7:0]         swr_data_i,
  input  logic               op_valid_i,
  input  logic [2:0]         op_kind_i,
  input  logic [ADDR_W-1:0]  op_addr_i,
  input  logic [SECTORS-1:0] lock_mask_i,
  output logic [7:0]         status_o,
  output logic               swr_resp_valid_o,
  output logic               swr_resp_ok_o,
  output logic               op_resp_valid_o,
  output logic               op_resp_ok_o
);
  logic               wd;
  logic [2:0]         bp;
  logic [SECTORS-1:0] prot;
  logic [SEC_W-1:0]   sector;
  logic               unused_addr;

  assign sector      = op_addr_i[ADDR_W-1 -: SEC_W];
  assign unused_addr = ^op_addr_i[SECTOR_AW-1:0];
  assign status_o    = {wd, 2'b00, bp, wel_i, wip_i};

  sr_guard_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .swr_valid_i  (swr_valid_i),
    .swr_data_i   (swr_data_i),
    .wel_i        (wel_i),
    .wip_i        (wip_i),
    .wp_n_i       (wp_n_i),
    .wd_o         (wd),
    .bp_o         (bp),
    .resp_valid_o (swr_resp_valid_o),
    .resp_ok_o    (swr_resp_ok_o)
  );

  sr_guard_map #(.SECTORS(SECTORS)) u_map (
    .bp_i   (bp),
    .prot_o (prot)
  );

  sr_guard_judge #(.SECTORS(SECTORS)) u_judge (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid_i   (op_valid_i),
    .op_kind_i    (op_kind_i),
    .sector_i     (sector),
    .prot_i       (prot),
    .lock_i       (lock_mask_i),
    .wel_i        (wel_i),
    .wip_i        (wip_i),
    .resp_valid_o (op_resp_valid_o),
    .resp_ok_o    (op_resp_ok_o)
  );
endmodule

// File: rtl/sr_guard_chk.sv
`timescale 1ns/1ps
module sr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n_i,
  input logic       wel_i,
  input logic       swr_valid_i,
  input logic       op_valid_i,
  input logic [2:0] op_kind_i,
  input logic [7:0] status_o,
  input logic       swr_resp_ok_o,
  input logic       op_resp_valid_o,
  input logic       op_resp_ok_o
);
  // R10
  op_resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid_i |=> op_resp_valid_o);

  // R10
  op_resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_i |=> !op_resp_valid_o);

  // R9
  op_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && !wel_i) |=> !op_resp_ok_o);

  // R8
  bulk_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && op_kind_i == 3'd5 && status_o[4:2] != 3'd0) |=> !op_resp_ok_o);

  // R5
  hw_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swr_valid_i && status_o[7] && !wp_n_i) |=> (!swr_resp_ok_o && $stable(status_o[7:2])));

  // R4
  swr_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swr_valid_i && !wel_i) |=> $stable(status_o[7:2]));
endmodule

bind sr_guard sr_guard_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .wp_n_i          (wp_n_i),
  .wel_i           (wel_i),
  .swr_valid_i     (swr_valid_i),
  .op_valid_i      (op_valid_i),
  .op_kind_i       (op_kind_i),
  .status_o        (status_o),
  .swr_resp_ok_o   (swr_resp_ok_o),
  .op_resp_valid_o (op_resp_valid_o),
  .op_resp_ok_o    (op_resp_ok_o)
);

// File: tb/sr_guard_bench.sv
`timescale 1ns/1ps
module sr_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        wp_n, wip, wel, swr_valid, op_valid;
  logic [7:0]  swr_data;
  logic [2:0]  op_kind;
  logic [18:0] op_addr;
  logic [7:0]  lock;
  logic [7:0]  status;
  logic        swr_rv, swr_ok, op_rv, op_ok;

  int total = 0;
  int bad = 0;
  logic       m_wd = 1'b0;
  logic [2:0] m_bp = 3'd0;

  sr_guard u_sr_guard (
    .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .wip_i(wip), .wel_i(wel),
    .swr_valid_i(swr_valid), .swr_data_i(swr_data), .op_valid_i(op_valid),
    .op_kind_i(op_kind), .op_addr_i(op_addr), .lock_mask_i(lock),
    .status_o(status), .swr_resp_valid_o(swr_rv), .swr_resp_ok_o(swr_ok),
    .op_resp_valid_o(op_rv), .op_resp_ok_o(op_ok)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int span_of(input logic [2:0] code);
    int n;
    if (code == 0) return 0;
    n = 1 << (code - 1);
    return (n > 8) ? 8 : n;
  endfunction

  function automatic logic exp_op(input logic [2:0] k, input int sec, input logic [2:0] b,
                                  input logic [7:0] lk, input logic w, input logic p);
    logic hit;
    hit = (sec >= 8 - span_of(b)) || lk[sec];
    if (!w || p) return 1'b0;
    if (k <= 3'd4) return !hit;
    if (k == 3'd5) return (b == 0) && (lk == 0);
    return 1'b0;
  endfunction

  task automatic swr(input logic [7:0] d, input logic w, input logic p, input logic wpn,
                     input string tag);
    logic ok;
    @(negedge clk);
    swr_valid = 1'b1; swr_data = d; wel = w; wip = p; wp_n = wpn;
    ok = w && !p && !(m_wd && !wpn);
    @(posedge clk); #1;
    chk(32'(swr_rv), 32'd1, "R10 status resp strobe");
    chk(32'(swr_ok), 32'(ok), tag);
    if (ok) begin m_wd = d[7]; m_bp = d[4:2]; end
    chk(32'(status), 32'({m_wd, 2'b00, m_bp, w, p}), tag);
    @(negedge clk);
    swr_valid = 1'b0;
  endtask

  task automatic op(input logic [2:0] k, input int sec, input logic [7:0] lk,
                    input logic w, input logic p, input string tag);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; lock = lk; wel = w; wip = p;
    op_addr = 19'((sec << 16) + (sec * 4096) + 37);
    @(posedge clk); #1;
    chk(32'(op_rv), 32'd1, "R10 op resp strobe");
    chk(32'(op_ok), 32'(exp_op(k, sec, m_bp, lk, w, p)), tag);
    @(negedge clk);
    op_valid = 1'b0;
    @(posedge clk); #1;
    chk(32'(op_rv), 32'd0, "R10 op resp single pulse");
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL R10 watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wp_n = 1'b1; wip = 1'b0; wel = 1'b0; swr_valid = 1'b0; op_valid = 1'b0;
    swr_data = 8'h00; op_kind = 3'd0; op_addr = '0; lock = 8'h00;
    #12;
    // R2 reset state
    chk(32'(status[7:2]), 32'd0, "R2 status after reset");
    chk(32'(swr_rv | op_rv), 32'd0, "R2 strobes after reset");
    rst_n = 1'b1;

    // R1 engine-owned bits follow inputs
    @(negedge clk); wel = 1'b1; wip = 1'b1; #1;
    chk(32'(status), 32'h03, "R1 wel/wip mirror");
    @(negedge clk); wel = 1'b0; wip = 1'b0; #1;
    chk(32'(status), 32'h00, "R1 wel/wip mirror low");

    // R3 ignored bits, R4 refusals
    swr(8'hFF, 1'b1, 1'b0, 1'b1, "R3 all-ones write");
    chk(32'(status), 32'h9E, "R3 ignored data bits");
    swr(8'h00, 1'b0, 1'b0, 1'b1, "R4 no latch");
    swr(8'h00, 1'b1, 1'b1, 1'b1, "R4 busy");
    // R5 freeze with pin low, then release with pin high
    swr(8'h00, 1'b1, 1'b0, 1'b0, "R5 hardware freeze");
    chk(32'(status[7]), 32'd1, "R5 wd kept");
    swr(8'h00, 1'b1, 1'b0, 1'b1, "R3 write with pin high");
    swr(8'h1C, 1'b1, 1'b0, 1'b0, "R3 pin low but wd clear");
    swr(8'h00, 1'b1, 1'b0, 1'b0, "R3 clear bp");

    // R6 R7 R8 full sweep of codes, kinds and sectors
    for (int b = 0; b < 8; b++) begin
      swr(8'(b << 2), 1'b1, 1'b0, 1'b1, "R3 set bp");
      for (int k = 0; k < 8; k++)
        for (int s = 0; s < 8; s++)
          op(3'(k), s, 8'h00, 1'b1, 1'b0, (k == 5) ? "R8 bulk vs bp" : "R6 R7 region map");
    end

    // R7 R8 lock mask with no bp
    swr(8'h00, 1'b1, 1'b0, 1'b1, "R3 clear bp");
    for (int l = 0; l < 8; l++)
      for (int k = 0; k < 6; k++)
        for (int s = 0; s < 8; s++)
          op(3'(k), s, 8'(1 << l), 1'b1, 1'b0, (k == 5) ? "R8 bulk vs lock" : "R7 lock mask");

    // R9 gating
    for (int k = 0; k < 8; k++) begin
      op(3'(k), 0, 8'h00, 1'b0, 1'b0, "R9 no write enable");
      op(3'(k), 0, 8'h00, 1'b1, 1'b1, "R9 busy");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule